// File: doc/BRIEF.md
# External Bus Grant Arbiter

This block decides, cycle by cycle, whether a processor core or an outside master owns the external memory port. An outside master raises an asynchronous bus request. The arbiter passes that request through a synchronizer. Once the port is free, it hands the bus over: it turns off the core's address, data and strobe drivers, raises the grant, and stops the core. When the request goes away, it reverses each of these steps, and the core continues from the point where it stopped.

The core reports its external traffic with three levels. The first marks each cycle of an access in flight. The second marks the final cycle of that access. The third marks a cycle in which the core needs the bus but cannot use it. The grant never interrupts an access that is already running. The grant can still fall between two accesses of the same instruction, because each access ends with its own final-cycle mark.

With the run-on-grant option set, the core keeps executing while the bus is granted away. It is stopped only once it reports that it needs the bus. A separate hung output tells the outside master that the core is waiting on it.

Top module: `bus_grant_arbiter`

## Requirements
- R1: With the port idle and `go_mode_i` low, a rise of `bus_req_i` makes `bus_grant_o` and `core_halt_o` rise on the third rising clock edge after it.
- R2: `bus_grant_o` does not rise on the edge that ends a cycle in which `acc_active_i` is high and `acc_last_i` is low. It may rise on the edge that ends the cycle in which `acc_last_i` is high.
- R3: `bus_oe_o` is the exact complement of `bus_grant_o` in every cycle.
- R4: With `go_mode_i` high, `core_halt_o` stays low while the bus is granted until a cycle in which `acc_pend_i` is high. It rises on the edge that ends that cycle. With `go_mode_i` low, `core_halt_o` equals `bus_grant_o`.
- R5: A fall of `bus_req_i` drops `bus_grant_o`, `core_halt_o` and `grant_hung_o` on the third rising edge after it. On the same edge, `bus_oe_o` returns high.
- R6: On each rising edge, `grant_hung_o` takes the value: (grant for the coming cycle) AND (`acc_pend_i` in the cycle just ended).
- R7: While `rst` is high, `acc_active_i`, `acc_last_i`, `acc_pend_i` and `go_mode_i` are ignored, and the request is still synchronized and granted. A grant given in reset always halts. The outputs power up with grant, halt and hung low and `bus_oe_o` high.
- R8: After the first access of a two-access instruction ends, the grant is inserted before the second access, even while `acc_pend_i` holds that second access waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset; masks the core status inputs |
| bus_req_i | input | 1 | Asynchronous bus request from the outside master |
| acc_active_i | input | 1 | Core external access in flight this cycle |
| acc_last_i | input | 1 | Final cycle of the access in flight |
| acc_pend_i | input | 1 | Core needs the external bus but is blocked |
| go_mode_i | input | 1 | Keep executing while the bus is granted |
| bus_grant_o | output | 1 | Bus granted to the outside master |
| grant_hung_o | output | 1 | Granted while the core waits for the bus |
| bus_oe_o | output | 1 | Enable for address, data and strobe drivers |
| core_halt_o | output | 1 | Stop the core |

## Verification
The assertions assume that the core behaves lawfully. It starts an access only in a cycle where `bus_grant_o` and `core_halt_o` are low. It marks exactly one final cycle per access. It asserts `acc_pend_i` only while it cannot use the bus. The bench stimulus honours these rules: it models a core that opens 1 to 3 cycle accesses only when it sees the bus free, and it raises its pending flag only while the bus is granted away. The request line, the run-on-grant option and reset are randomized freely, because the arbiter must accept any pattern on them.

// File: rtl/bga_pkg.sv
package bga_pkg;
  typedef struct packed {
    logic active;
    logic last;
    logic pend;
    logic go;
  } core_stat_t;

  function automatic core_stat_t mask_in_reset(input core_stat_t s, input logic r);
    core_stat_t m;
    m.active = s.active & ~r;
    m.last   = s.last   & ~r;
    m.pend   = s.pend   & ~r;
    m.go     = s.go     & ~r;
    return m;
  endfunction
endpackage

// File: rtl/bga_sync.sv
module bga_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain = '0;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk) chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bga_grant_ctrl.sv
module bga_grant_ctrl (
  input  logic clk,
  input  logic req_sync,
  input  logic busy_mid,
  output logic grant_next,
  output logic grant_q,
  output logic oe_q
);
  logic g_r  = 1'b0;
  logic oe_r = 1'b1;

  always_comb grant_next = req_sync & (g_r | ~busy_mid);

  always_ff @(posedge clk) begin
    g_r  <= grant_next;
    oe_r <= ~grant_next;
  end

  assign grant_q = g_r;
  assign oe_q    = oe_r;
endmodule

// File: rtl/bga_halt_ctrl.sv
module bga_halt_ctrl (
  input  logic clk,
  input  logic grant_next,
  input  logic pend,
  input  logic go,
  output logic halt_q,
  output logic hung_q
);
  logic halt_r = 1'b0;
  logic hung_r = 1'b0;

  always_ff @(posedge clk) begin
    halt_r <= grant_next & (~go | pend);
    hung_r <= grant_next & pend;
  end

  assign halt_q = halt_r;
  assign hung_q = hung_r;
endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_req_i,
  input  logic acc_active_i,
  input  logic acc_last_i,
  input  logic acc_pend_i,
  input  logic go_mode_i,
  output logic bus_grant_o,
  output logic grant_hung_o,
  output logic bus_oe_o,
  output logic core_halt_o
);
  import bga_pkg::*;

  core_stat_t raw_stat, stat;
  logic req_sync;
  logic busy_mid;
  logic grant_next;

  always_comb begin
    raw_stat.active = acc_active_i;
    raw_stat.last   = acc_last_i;
    raw_stat.pend   = acc_pend_i;
    raw_stat.go     = go_mode_i;
    stat     = mask_in_reset(raw_stat, rst);
    busy_mid = stat.active & ~stat.last;
  end

  bga_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (bus_req_i),
    .q   (req_sync)
  );

  bga_grant_ctrl u_grant (
    .clk        (clk),
    .req_sync   (req_sync),
    .busy_mid   (busy_mid),
    .grant_next (grant_next),
    .grant_q    (bus_grant_o),
    .oe_q       (bus_oe_o)
  );

  bga_halt_ctrl u_halt (
    .clk        (clk),
    .grant_next (grant_next),
    .pend       (stat.pend),
    .go         (stat.go),
    .halt_q     (core_halt_o),
    .hung_q     (grant_hung_o)
  );
endmodule

// File: rtl/bus_grant_arbiter_chk.sv
module bus_grant_arbiter_chk (
  input logic clk,
  input logic rst,
  input logic req_sync,
  input logic acc_active_i,
  input logic acc_last_i,
  input logic acc_pend_i,
  input logic go_mode_i,
  input logic bus_grant_o,
  input logic grant_hung_o,
  input logic bus_oe_o,
  input logic core_halt_o
);
  p_oe_inverse_r3: assert property (@(posedge clk) disable iff (rst)
    bus_oe_o != bus_grant_o);

  p_no_grant_mid_access_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_active_i && !acc_last_i && !bus_grant_o) |=> !bus_grant_o);

  p_grant_needs_req_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_grant_o) |-> $past(req_sync));

  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_grant_o && !req_sync) |=> (!bus_grant_o && bus_oe_o && !core_halt_o && !grant_hung_o));

  p_go_runs_r4: assert property (@(posedge clk) disable iff (rst)
    (go_mode_i && !acc_pend_i) |=> !core_halt_o);

  p_halt_follows_grant_r4: assert property (@(posedge clk) disable iff (rst)
    core_halt_o |-> bus_grant_o);

  p_hung_in_grant_r6: assert property (@(posedge clk) disable iff (rst)
    grant_hung_o |-> bus_grant_o);
endmodule

bind bus_grant_arbiter bus_grant_arbiter_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_sync     (req_sync),
  .acc_active_i (acc_active_i),
  .acc_last_i   (acc_last_i),
  .acc_pend_i   (acc_pend_i),
  .go_mode_i    (go_mode_i),
  .bus_grant_o  (bus_grant_o),
  .grant_hung_o (grant_hung_o),
  .bus_oe_o     (bus_oe_o),
  .core_halt_o  (core_halt_o)
);

// File: tb/bus_grant_arbiter_test.sv
`timescale 1ns/1ps
module bus_grant_arbiter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, act = 1'b0, last = 1'b0, pend = 1'b0, go = 1'b0;
  logic grant, hung, oe, halt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bus_grant_arbiter uut (
    .clk(clk), .rst(rst), .bus_req_i(req), .acc_active_i(act),
    .acc_last_i(last), .acc_pend_i(pend), .go_mode_i(go),
    .bus_grant_o(grant), .grant_hung_o(hung), .bus_oe_o(oe), .core_halt_o(halt));

  // Reference model built from the requirements
  logic m_s1 = 0, m_s2 = 0, m_g = 0, m_oe = 1, m_halt = 0, m_hung = 0;

  function automatic logic next_grant(logic s2, logic g, logic a, logic l, logic r);
    logic busy;
    busy = a & ~l & ~r;
    return s2 & (g | ~busy);
  endfunction

  always @(posedge clk) begin
    logic gn;
    gn = next_grant(m_s2, m_g, act, last, rst);
    m_g    <= gn;
    m_oe   <= ~gn;
    m_halt <= gn & (~(go & ~rst) | (pend & ~rst));
    m_hung <= gn & pend & ~rst;
    m_s2   <= m_s1;
    m_s1   <= req;
    cycles <= cycles + 1;
  end

  task automatic chk(string tag, string name, logic actual, logic expect_v);
    checks++;
    if (actual !== expect_v) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, name, actual, expect_v, $time);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "grant", grant, m_g);
    chk("R3", "oe", oe, m_oe);
    chk(tag, "halt", halt, m_halt);
    chk("R6", "hung", hung, m_hung);
  endtask

  task automatic tick(string tag);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int lat;
    int busy_left;
    void'($urandom(32'h5eed_0a11));

    // R7: power-up state and arbitration during reset
    tick("R7");
    chk("R7", "reset grant", grant, 1'b0);
    chk("R7", "reset oe", oe, 1'b1);
    act = 1; pend = 1; go = 1; req = 1;
    lat = 0;
    repeat (6) begin tick("R7"); if (!grant) lat++; end
    chk("R7", "grant in reset", grant, 1'b1);
    chk("R7", "halt in reset", halt, 1'b1);
    chk("R7", "hung masked", hung, 1'b0);
    req = 0; act = 0; pend = 0; go = 0;
    repeat (4) tick("R7");
    rst = 0;
    repeat (2) tick("R1");

    // R1: idle request latency
    req = 1; lat = 0;
    while (!grant && lat < 10) begin tick("R1"); lat++; end
    chk("R1", "idle latency==3", (lat == 3), 1'b1);
    chk("R1", "halt with grant", halt, 1'b1);
    // R5: release latency
    req = 0; lat = 0;
    while (grant && lat < 10) begin tick("R5"); lat++; end
    chk("R5", "release latency==3", (lat == 3), 1'b1);
    chk("R5", "oe back", oe, 1'b1);

    // R2: request during a 5-cycle access
    act = 1; last = 0; req = 1;
    repeat (4) begin tick("R2"); chk("R2", "no grant mid access", grant, 1'b0); end
    last = 1;
    tick("R2");
    act = 0; last = 0;
    chk("R2", "grant after last", grant, 1'b1);
    req = 0;
    repeat (4) tick("R5");

    // R8: grant between two accesses, second access pending
    act = 1; last = 0;
    tick("R8");
    last = 1; req = 1;
    tick("R8");
    act = 0; last = 0; pend = 1;
    repeat (3) tick("R8");
    chk("R8", "grant between halves", grant, 1'b1);
    chk("R8", "hung while pending", hung, 1'b1);
    req = 0;
    repeat (4) tick("R8");
    chk("R8", "released", grant, 1'b0);
    pend = 0;
    tick("R8");

    // R4: run-on-grant, halt only once bus needed
    go = 1; req = 1;
    repeat (5) tick("R4");
    chk("R4", "granted", grant, 1'b1);
    chk("R4", "core runs", halt, 1'b0);
    pend = 1;
    tick("R4");
    chk("R4", "halt after pend", halt, 1'b1);
    req = 0;
    repeat (4) tick("R4");
    pend = 0; go = 0;
    tick("R4");

    // Random phase against the reference model
    busy_left = 0;
    for (int n = 0; n < 4000; n++) begin
      tick("R1");
      if (($urandom % 12) == 0) req = ~req;
      if (($urandom % 97) == 0) go = ~go;
      rst = (($urandom % 400) == 0);
      if (busy_left > 0) begin
        act = 1; last = (busy_left == 1); busy_left--;
      end else if (!grant && !halt && (($urandom % 3) == 0)) begin
        int len;
        len = 1 + ($urandom % 3);
        act = 1; last = (len == 1); busy_left = len - 1;
      end else begin
        act = 0; last = 0;
      end
      pend = grant ? (($urandom % 2) == 0) : 1'b0;
    end
    rst = 0; req = 0; act = 0; last = 0; pend = 0;
    repeat (4) tick("R5");
    finish_run();
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired after %0d cycles", cycles);
    finish_run();
  end
endmodule